// File: doc/BRIEF.md
# Tower-Field GF(2^4) Multiplier and Squarer

This block multiplies two 4-bit elements of the field GF(2^4). The field is built as a degree-2 extension of GF(2^2). Each operand splits into a high 2-bit half `a1` (bits 3:2) and a low 2-bit half `a0` (bits 1:0), and the element is `a1*x + a0`. The extension modulus is `x^2 + x + phi`, where `phi` is the GF(2^2) element `2'b10`. Inside a half, bit 1 is the coefficient of the subfield root `y`, bit 0 is the constant term, and `y^2 = y + 1`. The field identity is `4'h1`.

The product uses a three-multiply split. The high half is `(a0+a1)(b0+b1) + a0*b0`. The low half is `a0*b0 + phi*a1*b1`. Scaling by `phi` costs one XOR. A separate squaring path uses only XOR gates, because `v*v = v` holds for single bits. When the select input is 1, that path squares `op_a` and ignores `op_b`.

When the parameter `REG_OUT` is 1 (the default), the result is registered. A synchronous active-low reset clears that register. When `REG_OUT` is 0, the block is purely combinational and the clock and reset have no effect.

Top module: `gf16_tower_mul`

## Requirements
- R1: With `op_sel` = 0, `prod` equals the field product of `op_a` and `op_b` for all 256 operand pairs. The field encoding is the one given above.
- R2: Multiplication commutes: swapping `op_a` and `op_b` gives the same `prod`.
- R3: With `op_sel` = 0, if either operand is `4'h0` then `prod` is `4'h0`.
- R4: With `op_sel` = 0, if either operand is `4'h1` then `prod` equals the other operand.
- R5: The product of two nonzero operands is never zero. Every nonzero `op_a` has exactly one `op_b` whose product is `4'h1`.
- R6: With `op_sel` = 1, `prod` equals the R1 product of `op_a` with itself. Its bit 3 equals bit 3 of `op_a`.
- R7: With `op_sel` = 1, the value on `op_b` has no effect on `prod`.
- R8: With `REG_OUT` = 1, `prod` updates on the first rising clock edge after its inputs settle and holds its value until the next edge.
- R9: With `REG_OUT` = 1, a rising edge with `rst_n` low clears `prod` to `4'h0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 4 | First operand; the only operand in square mode |
| op_b | input | 4 | Second operand; ignored in square mode |
| op_sel | input | 1 | 0 = multiply, 1 = square `op_a` |
| prod | output | 4 | Result |

## Verification
Multiply and square share one output register, so they can fall in adjacent cycles. The mode select may flip at the same edge where the operands change. The bench alternates `op_sel` on back-to-back cycles while it walks `op_b` through values that would change a product. Each registered result must match the operation selected at its own edge. It must never show the other mode's result or a value left over from the previous cycle.

// File: rtl/gf16_tower_pkg.sv
// Shared widths and types for the tower-field GF(2^4) arithmetic.
package gf16_tower_pkg;
    localparam int SUB_W  = 2;
    localparam int ELEM_W = 2 * SUB_W;
    typedef logic [SUB_W-1:0]  sub_t;
    typedef logic [ELEM_W-1:0] elem_t;
    typedef enum logic {OP_MUL = 1'b0, OP_SQR = 1'b1} op_e;
endpackage

// File: rtl/gf4_sub_mul.sv
// GF(2^2) multiplier, modulus y^2 + y + 1.
// Three-AND split; bit 1 is the y coefficient. Purely combinational.
module gf4_sub_mul
    import gf16_tower_pkg::*;
(
    input  sub_t x,
    input  sub_t w,
    output sub_t z
);
    logic m_lo, m_hi, m_mid;

    // Partial products: low, high and cross-sum terms.
    always_comb begin
        m_lo  = x[0] & w[0];
        m_hi  = x[1] & w[1];
        m_mid = (x[0] ^ x[1]) & (w[0] ^ w[1]);
        z     = {m_mid ^ m_lo, m_lo ^ m_hi};
    end
endmodule

// File: rtl/gf4_sub_scale.sv
// Scales a GF(2^2) element by the extension constant phi = y (2'b10).
// Costs one XOR; purely combinational.
module gf4_sub_scale
    import gf16_tower_pkg::*;
(
    input  sub_t x,
    output sub_t z
);
    // (u1*y + u0)*y = (u1^u0)*y + u1
    always_comb z = {x[1] ^ x[0], x[1]};
endmodule

// File: rtl/gf16_squarer.sv
// XOR-only squarer for GF((2^2)^2) with modulus x^2 + x + phi.
// High half = a1^2; low half = a0^2 + phi*a1^2, with single-bit products folded.
module gf16_squarer
    import gf16_tower_pkg::*;
(
    input  elem_t a,
    output elem_t z
);
    // Folded bit equations of the square.
    always_comb begin
        z[3] = a[3];
        z[2] = a[3] ^ a[2];
        z[1] = a[2] ^ a[1];
        z[0] = a[3] ^ a[1] ^ a[0];
    end
endmodule

// File: rtl/gf16_tower_mul.sv
// Tower-field GF(2^4) multiplier with an XOR-only square mode.
// Assumes the operand encoding {a1,a0}, each half over GF(2^2).
// REG_OUT selects a registered (1) or combinational (0) result.
module gf16_tower_mul
    import gf16_tower_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ELEM_W-1:0] op_a,
    input  logic [ELEM_W-1:0] op_b,
    input  logic              op_sel,
    output logic [ELEM_W-1:0] prod
);
    localparam int N_SUBMUL = 3;

    sub_t  a_lo, a_hi, b_lo, b_hi, a_sum, b_sum;
    sub_t  mx [N_SUBMUL];
    sub_t  mw [N_SUBMUL];
    sub_t  mz [N_SUBMUL];
    sub_t  hi_scaled;
    elem_t mul_res, sq_res, next_res;

    // Split operands into halves and form the Karatsuba sums.
    always_comb begin
        a_lo  = op_a[SUB_W-1:0];
        a_hi  = op_a[ELEM_W-1:SUB_W];
        b_lo  = op_b[SUB_W-1:0];
        b_hi  = op_b[ELEM_W-1:SUB_W];
        a_sum = a_lo ^ a_hi;
        b_sum = b_lo ^ b_hi;
        mx[0] = a_lo;  mw[0] = b_lo;
        mx[1] = a_hi;  mw[1] = b_hi;
        mx[2] = a_sum; mw[2] = b_sum;
    end

    // Three subfield multipliers.
    for (genvar g = 0; g < N_SUBMUL; g++) begin : g_sub
        gf4_sub_mul u_mul (.x(mx[g]), .w(mw[g]), .z(mz[g]));
    end

    gf4_sub_scale u_scale (.x(mz[1]), .z(hi_scaled));
    gf16_squarer  u_sq    (.a(op_a), .z(sq_res));

    // Recombine halves and choose the mode.
    always_comb begin
        mul_res  = {mz[2] ^ mz[0], mz[0] ^ hi_scaled};
        next_res = (op_e'(op_sel) == OP_SQR) ? sq_res : mul_res;
    end

    if (REG_OUT) begin : g_reg
        // Result register with synchronous active-low reset.
        always_ff @(posedge clk) begin
            if (!rst_n) prod <= '0;
            else        prod <= next_res;
        end
    end else begin : g_comb
        // Combinational result path.
        always_comb prod = next_res;
    end
endmodule

// File: rtl/gf16_tower_mul_chk.sv
// Property checker for gf16_tower_mul, attached with bind.
module gf16_tower_mul_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] op_a,
    input logic [3:0] op_b,
    input logic       op_sel,
    input logic [3:0] prod
);
    if (REG_OUT) begin : g_seq
        p_mul_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!op_sel && (op_a == 4'h0 || op_b == 4'h0)) |=> prod == 4'h0);
        p_mul_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!op_sel && op_a == 4'h1) |=> prod == $past(op_b));
        p_no_zero_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!op_sel && op_a != 4'h0 && op_b != 4'h0) |=> prod != 4'h0);
        p_sq_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
            op_sel |=> prod[3] == $past(op_a[3]));
        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($stable(op_a) && $stable(op_b) && $stable(op_sel)) |=> $stable(prod));
    end else begin : g_comb
        // Combinational variants of R3 and R6.
        always_comb begin
            if (!op_sel && (op_a == 4'h0 || op_b == 4'h0))
                p_mul_zero_r3: assert (prod == 4'h0);
            if (op_sel)
                p_sq_msb_r6: assert (prod[3] == op_a[3]);
        end
    end
endmodule

bind gf16_tower_mul gf16_tower_mul_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .op_sel(op_sel), .prod(prod)
);

// File: tb/gf16_tower_mul_tb.sv
// Exhaustive bench for gf16_tower_mul with the registered output.
module gf16_tower_mul_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_a = '0, op_b = '0;
    logic       op_sel = 1'b0;
    logic [3:0] prod;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;
    logic [3:0] tbl [16][16];

    gf16_tower_mul #(.REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .op_sel(op_sel), .prod(prod)
    );

    always #10 clk = ~clk;

    // Schoolbook GF(2^2) product, reduced by y^2 = y + 1.
    function automatic logic [1:0] ref2(input logic [1:0] u, input logic [1:0] v);
        logic c0, c1, c2;
        c0 = u[0] & v[0];
        c1 = (u[0] & v[1]) ^ (u[1] & v[0]);
        c2 = u[1] & v[1];
        return {c1 ^ c2, c0 ^ c2};
    endfunction

    // Schoolbook GF(2^4) product, reduced by x^2 = x + phi.
    function automatic logic [3:0] ref4(input logic [3:0] a, input logic [3:0] b);
        logic [1:0] d0, d1, d2;
        d2 = ref2(a[3:2], b[3:2]);
        d1 = ref2(a[3:2], b[1:0]) ^ ref2(a[1:0], b[3:2]);
        d0 = ref2(a[1:0], b[1:0]);
        return {d1 ^ d2, d0 ^ ref2(2'b10, d2)};
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive at the falling edge, sample after the next rising edge.
    task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic s);
        @(negedge clk);
        op_a = a; op_b = b; op_sel = s;
        @(posedge clk);
        #5;
    endtask

    initial begin
        logic [3:0] prev;
        int ninv;
        repeat (2) @(posedge clk);
        #5;
        check("R9 reset", prod, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: full multiply table; R3/R4 boundaries inside it.
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                apply(4'(i), 4'(j), 1'b0);
                tbl[i][j] = prod;
                check("R1 mul", prod, ref4(4'(i), 4'(j)));
                if (i == 0 || j == 0) check("R3 zero", prod, 4'h0);
                if (i == 1) check("R4 one", prod, 4'(j));
            end
        end

        // R2 and R5 from the recorded table.
        for (int i = 1; i < 16; i++) begin
            ninv = 0;
            for (int j = 0; j < 16; j++) begin
                check("R2 commute", tbl[i][j], tbl[j][i]);
                if (j != 0 && tbl[i][j] == 4'h0) check("R5 nonzero", tbl[i][j], 4'h1);
                if (tbl[i][j] == 4'h1) ninv++;
            end
            check("R5 inverse", 4'(ninv), 4'h1);
        end

        // R6/R7: square mode with b swept.
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j += 5) begin
                apply(4'(i), 4'(j), 1'b1);
                check("R6 square", prod, ref4(4'(i), 4'(i)));
                check("R7 b ignored", prod, tbl[i][i]);
            end
        end

        // Mode flips on consecutive edges (R6 vs R1 interleave).
        for (int i = 2; i < 16; i++) begin
            apply(4'(i), 4'(17 - i), 1'b1);
            check("R6 interleave", prod, ref4(4'(i), 4'(i)));
            apply(4'(i), 4'(17 - i), 1'b0);
            check("R1 interleave", prod, ref4(4'(i), 4'(17 - i)));
        end

        // R8: output holds before the edge, updates after.
        apply(4'h7, 4'h9, 1'b0);
        prev = prod;
        @(negedge clk);
        op_a = 4'hB; op_b = 4'h6;
        #5;
        check("R8 hold", prod, prev);
        @(posedge clk);
        #5;
        check("R8 update", prod, ref4(4'hB, 4'h6));

        // R9: reset mid-stream.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #5;
        check("R9 clear", prod, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule